// File: doc/BRIEF.md
# Minimal RV64 Two-Instruction Core

This block is a very small 64-bit RISC-V execution unit that understands two instructions: add-immediate (ADDI) and load-doubleword (LD). It holds a 32-entry register file whose entry 0 is hardwired to zero, a program counter and a next-PC register. It steps through fetch, execute, optional load and retire, one instruction at a time, with no overlap between instructions.

Instructions arrive on a synchronous fetch port. A request in one cycle returns the word in the next cycle. Load data arrives on a byte-wide synchronous read port with the same one-cycle latency. That port can flag a failed access for each byte. The core fetches the eight bytes of a doubleword in order and builds the value itself. Any word that is neither of the two encodings stops the core: it raises a sticky illegal flag and leaves the register file and PC untouched. It stays stopped until reset.

Top module: `rvp_core`

## Requirements
- R1: Register 0 always reads as zero, and any write aimed at register 0 is discarded.
- R2: A word with bits [6:0] = 0010011 and bits [14:12] = 000 is an ADDI. It writes register [11:7] with register [19:15] plus bits [31:20] sign-extended to 64 bits. The sum wraps modulo 2^64.
- R3: A word with bits [6:0] = 0000011 and bits [14:12] = 011 is an LD. It uses the same field positions as R2, and its byte address is register [19:15] plus the sign-extended immediate, modulo 2^64.
- R4: An LD issues exactly eight single-byte read requests, at addresses A, A+1, …, A+7 in that order, never in back-to-back cycles and never in the same cycle as a fetch. The result is little-endian: the byte from A lands in bits [7:0], and the result is written to the destination register.
- R5: If any of the eight byte reads reports failure, the destination register receives all zeros. An LD whose destination is register 0 still performs all eight reads.
- R6: Any other word is illegal. From the cycle after the word is returned, illegal_o stays high until reset. After that the core issues no fetch, no read and no retire, and writes no register.
- R7: Instruction fetches go to consecutive word addresses. After each retire, the next fetch address is the previous fetch address plus 4.
- R8: retire_o is a single-cycle pulse, given exactly once for each completed instruction.
- R9: After reset, the first fetch goes to RESET_PC and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ifetch_req_o | output | 1 | Instruction fetch request |
| ifetch_addr_o | output | 64 | Fetch address (current PC) |
| ifetch_data_i | input | 32 | Instruction word, valid the cycle after the request |
| dread_req_o | output | 1 | Data byte read request |
| dread_addr_o | output | 64 | Data byte address |
| dread_data_i | input | 8 | Read byte, valid the cycle after the request |
| dread_err_i | input | 1 | Read failure, valid with dread_data_i |
| retire_o | output | 1 | One-cycle pulse per retired instruction |
| illegal_o | output | 1 | Sticky flag: an illegal instruction was met |

## Verification
Two events can land in the same cycle. The register-file read of rs1 for a new instruction can coincide with the write of that same register when rd equals rs1. Separately, a failure flag on the last load byte coincides with the register write-back. The bench provokes the first with directed cases such as adding to a register in place and a wrap to zero. It provokes the second with loads that straddle the end of the valid data range, and random programs reuse registers often enough to hit both again. In each case the outcome is judged by the address of a later load that uses the affected register as its base, compared against a model that executes the same program.

// File: rtl/rvp_pkg.sv
package rvp_pkg;
  localparam int ILEN = 32;
  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [2:0] F3_ADD    = 3'b000;
  localparam logic [2:0] F3_DWORD  = 3'b011;

  typedef enum logic [2:0] {
    ST_FETCH, ST_EXEC, ST_LOAD, ST_RETIRE, ST_HALT
  } core_st_e;
endpackage

// File: rtl/rvp_regfile.sv
module rvp_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   raddr_i,
  output logic [XLEN-1:0] rdata_o,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i == '0) ? '0 : regs_q[raddr_i];
endmodule

// File: rtl/rvp_decode.sv
module rvp_decode
  import rvp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 5
) (
  input  logic [ILEN-1:0] instr_i,
  output logic            is_addi_o,
  output logic            is_ld_o,
  output logic [AW-1:0]   rs1_o,
  output logic [AW-1:0]   rd_o,
  output logic [XLEN-1:0] imm_o
);
  logic [6:0]  opc;
  logic [2:0]  f3;
  logic [11:0] imm12;

  assign opc   = instr_i[6:0];
  assign f3    = instr_i[14:12];
  assign imm12 = instr_i[31:20];

  assign is_addi_o = (opc == OPC_OPIMM) && (f3 == F3_ADD);
  assign is_ld_o   = (opc == OPC_LOAD)  && (f3 == F3_DWORD);
  assign rs1_o     = instr_i[15 +: AW];
  assign rd_o      = instr_i[7 +: AW];
  assign imm_o     = {{(XLEN-12){imm12[11]}}, imm12};
endmodule

// File: rtl/rvp_load_unit.sv
module rvp_load_unit #(
  parameter int XLEN = 64,
  localparam int NBYTES = XLEN / 8,
  localparam int CW = $clog2(NBYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] base_i,
  output logic            req_o,
  output logic [XLEN-1:0] addr_o,
  input  logic [7:0]      byte_i,
  input  logic            err_i,
  output logic            done_o,
  output logic [XLEN-1:0] data_o
);
  logic            busy_q, phase_q, err_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] base_q, buf_q, asm_d;
  logic            last_byte;

  assign last_byte = (cnt_q == CW'(NBYTES - 1));
  assign req_o     = busy_q && !phase_q;
  assign addr_o    = base_q + {{(XLEN-CW){1'b0}}, cnt_q};
  assign done_o    = busy_q && phase_q && last_byte;

  // final lane comes straight from the port so write-back needs no extra cycle
  always_comb begin
    asm_d = buf_q;
    asm_d[XLEN-1 -: 8] = byte_i;
  end
  assign data_o = (err_q || err_i) ? '0 : asm_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      buf_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      base_q  <= base_i;
    end else if (busy_q) begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        buf_q[cnt_q*8 +: 8] <= byte_i;
        err_q <= err_q | err_i;
        if (last_byte) busy_q <= 1'b0;
        else           cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rvp_core.sv
module rvp_core
  import rvp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter logic [XLEN-1:0] RESET_PC = 64'h1000,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            ifetch_req_o,
  output logic [XLEN-1:0] ifetch_addr_o,
  input  logic [ILEN-1:0] ifetch_data_i,
  output logic            dread_req_o,
  output logic [XLEN-1:0] dread_addr_o,
  input  logic [7:0]      dread_data_i,
  input  logic            dread_err_i,
  output logic            retire_o,
  output logic            illegal_o
);
  core_st_e        st_q;
  logic [XLEN-1:0] pc_q, npc_q;
  logic [AW-1:0]   ld_rd_q;

  logic            is_addi, is_ld;
  logic [AW-1:0]   rs1, rd;
  logic [XLEN-1:0] imm, rs1_val, sum;
  logic            in_exec, ld_start, ld_done;
  logic [XLEN-1:0] ld_data;
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  rvp_decode #(.XLEN(XLEN), .AW(AW)) u_dec (
    .instr_i   (ifetch_data_i),
    .is_addi_o (is_addi),
    .is_ld_o   (is_ld),
    .rs1_o     (rs1),
    .rd_o      (rd),
    .imm_o     (imm)
  );

  rvp_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rs1),
    .rdata_o (rs1_val),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata)
  );

  rvp_load_unit #(.XLEN(XLEN)) u_ld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ld_start),
    .base_i  (sum),
    .req_o   (dread_req_o),
    .addr_o  (dread_addr_o),
    .byte_i  (dread_data_i),
    .err_i   (dread_err_i),
    .done_o  (ld_done),
    .data_o  (ld_data)
  );

  assign in_exec  = (st_q == ST_EXEC);
  assign sum      = rs1_val + imm;
  assign ld_start = in_exec && is_ld;
  assign rf_we    = (in_exec && is_addi) || ((st_q == ST_LOAD) && ld_done);
  assign rf_waddr = in_exec ? rd : ld_rd_q;
  assign rf_wdata = in_exec ? sum : ld_data;

  assign ifetch_req_o  = (st_q == ST_FETCH);
  assign ifetch_addr_o = pc_q;
  assign retire_o      = (st_q == ST_RETIRE);
  assign illegal_o     = (st_q == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FETCH;
      pc_q    <= RESET_PC;
      npc_q   <= RESET_PC;
      ld_rd_q <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: st_q <= ST_EXEC;
        ST_EXEC: begin
          if (is_addi) begin
            npc_q <= pc_q + XLEN'(4);
            st_q  <= ST_RETIRE;
          end else if (is_ld) begin
            npc_q   <= pc_q + XLEN'(4);
            ld_rd_q <= rd;
            st_q    <= ST_LOAD;
          end else begin
            st_q <= ST_HALT;
          end
        end
        ST_LOAD:   if (ld_done) st_q <= ST_RETIRE;
        ST_RETIRE: begin
          pc_q <= npc_q;
          st_q <= ST_FETCH;
        end
        ST_HALT:   st_q <= ST_HALT;
        default:   st_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/rvp_core_chk.sv
module rvp_core_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ifetch_req_o,
  input logic [XLEN-1:0] ifetch_addr_o,
  input logic            dread_req_o,
  input logic [XLEN-1:0] dread_addr_o,
  input logic            retire_o,
  input logic            illegal_o
);
  AST_RETIRE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o); // R8

  AST_NEXT_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> ifetch_req_o && (ifetch_addr_o == $past(ifetch_addr_o) + XLEN'(4))); // R7

  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ifetch_req_o && dread_req_o)); // R4

  AST_READ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dread_req_o |=> !dread_req_o); // R4

  AST_BYTE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dread_req_o && $past(dread_req_o, 2)) |->
      (dread_addr_o == $past(dread_addr_o, 2) + XLEN'(1))); // R4

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!ifetch_req_o && !dread_req_o && !retire_o)); // R6

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o); // R6
endmodule

bind rvp_core rvp_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ifetch_req_o  (ifetch_req_o),
  .ifetch_addr_o (ifetch_addr_o),
  .dread_req_o   (dread_req_o),
  .dread_addr_o  (dread_addr_o),
  .retire_o      (retire_o),
  .illegal_o     (illegal_o)
);

// File: tb/sim_rvp_core.sv
`timescale 1ns/1ps
module sim_rvp_core;
  localparam logic [63:0] RST_PC = 64'h1000;
  localparam int DBYTES = 1024;
  localparam int IWORDS = 1024;
  localparam int MAXLD  = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ifetch_req, dread_req, dread_err, retire, illegal;
  logic [63:0] ifetch_addr, dread_addr;
  logic [31:0] ifetch_data;
  logic [7:0]  dread_data;

  logic [31:0] imem [IWORDS];
  logic [7:0]  dmem [DBYTES];
  logic [63:0] mreg [32];
  logic [63:0] exp_la [MAXLD];
  string       la_tag [MAXLD];
  int n_prog, n_la;
  int fetch_idx, ld_idx, byte_k, retires, quiet_bad, pulse_bad;
  logic prev_ret;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  rvp_core #(.RESET_PC(RST_PC)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ifetch_req_o(ifetch_req), .ifetch_addr_o(ifetch_addr), .ifetch_data_i(ifetch_data),
    .dread_req_o(dread_req), .dread_addr_o(dread_addr), .dread_data_i(dread_data),
    .dread_err_i(dread_err), .retire_o(retire), .illegal_o(illegal)
  );

  // behavioural memories, one-cycle latency
  always @(posedge clk) begin
    if (ifetch_req) ifetch_data <= imem[((ifetch_addr - RST_PC) >> 2) % IWORDS];
    if (dread_req) begin
      if (dread_addr < 64'(DBYTES)) begin
        dread_data <= dmem[dread_addr[9:0]];
        dread_err  <= 1'b0;
      end else begin
        dread_data <= 8'($urandom);
        dread_err  <= 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sext12(input logic [11:0] v);
    return {{52{v[11]}}, v};
  endfunction

  function automatic logic [63:0] ld_val(input logic [63:0] a);
    logic [63:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      if (a + 64'(k) >= 64'(DBYTES)) return '0;
      v[k*8 +: 8] = dmem[10'(a + 64'(k))];
    end
    return v;
  endfunction

  function automatic bit is_legal(input logic [31:0] w);
    return ((w[6:0] == 7'b0010011) && (w[14:12] == 3'b000)) ||
           ((w[6:0] == 7'b0000011) && (w[14:12] == 3'b011));
  endfunction

  task automatic prog_clear();
    for (int i = 0; i < IWORDS; i++) imem[i] = 32'h0;
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    n_prog = 0; n_la = 0;
  endtask

  task automatic emit_addi(input int rd, input int rs1, input logic [11:0] imm);
    imem[n_prog++] = {imm, 5'(rs1), 3'b000, 5'(rd), 7'b0010011};
    if (rd != 0) mreg[rd] = mreg[rs1] + sext12(imm);
  endtask

  task automatic emit_ld(input int rd, input int rs1, input logic [11:0] imm, input string tag);
    logic [63:0] a;
    a = mreg[rs1] + sext12(imm);
    imem[n_prog++] = {imm, 5'(rs1), 3'b011, 5'(rd), 7'b0000011};
    la_tag[n_la] = tag;
    exp_la[n_la++] = a;
    if (rd != 0) mreg[rd] = ld_val(a);
  endtask

  task automatic emit_word(input logic [31:0] w);
    imem[n_prog++] = w;
  endtask

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (illegal && (ifetch_req || dread_req || retire)) quiet_bad++;
      if (retire && prev_ret) pulse_bad++;
      prev_ret <= retire;
      if (retire) retires++;
      if (ifetch_req) begin
        check(ifetch_addr == RST_PC + 64'(4 * fetch_idx), (fetch_idx == 0) ? "R9 first fetch" : "R7 fetch addr",
              ifetch_addr, RST_PC + 64'(4 * fetch_idx));
        fetch_idx++;
      end
      if (dread_req) begin
        check(ld_idx < n_la && dread_addr == exp_la[ld_idx] + 64'(byte_k),
              (ld_idx < n_la) ? la_tag[ld_idx] : "R4 extra read", dread_addr, exp_la[ld_idx] + 64'(byte_k));
        byte_k++;
        if (byte_k == 8) begin byte_k = 0; ld_idx++; end
      end
    end else begin
      prev_ret <= 1'b0;
    end
  end

  task automatic run_phase(input string nm);
    int cyc = 0;
    fetch_idx = 0; ld_idx = 0; byte_k = 0; retires = 0; quiet_bad = 0; pulse_bad = 0;
    @(negedge clk) rst_n = 1'b1;
    while (!illegal && cyc < 60000) begin @(negedge clk); cyc++; end
    check(cyc < 60000, {"R6 reach halt ", nm}, 64'(cyc), 64'd60000);
    repeat (20) @(negedge clk);
    check(illegal == 1'b1, {"R6 sticky ", nm}, 64'(illegal), 64'd1);
    check(quiet_bad == 0, {"R6 quiet after halt ", nm}, 64'(quiet_bad), 64'd0);
    check(retires == n_prog - 1, {"R8 retire count ", nm}, 64'(retires), 64'(n_prog - 1));
    check(pulse_bad == 0, {"R8 single pulse ", nm}, 64'(pulse_bad), 64'd0);
    check(fetch_idx == n_prog, {"R7 fetch count ", nm}, 64'(fetch_idx), 64'(n_prog));
    check(ld_idx == n_la && byte_k == 0, {"R4 load count ", nm}, 64'(ld_idx), 64'(n_la));
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DBYTES; i++) dmem[i] = 8'($urandom);
    // little-endian pointer at 96: value 0x012a
    dmem[96] = 8'h2a; dmem[97] = 8'h01;
    for (int i = 98; i < 104; i++) dmem[i] = 8'h00;
    dread_data = '0; dread_err = 1'b0; ifetch_data = '0; prev_ret = 1'b0;
    repeat (3) @(negedge clk);

    // phase A: directed corners
    prog_clear();
    emit_addi(7, 0, 12'd100);                    // R2
    emit_addi(0, 0, 12'd55);                     // R1 write dropped
    emit_ld(5, 0, 12'd8, "R1 x0 base");
    emit_ld(6, 7, 12'hffc, "R3 negative imm");
    emit_ld(8, 6, 12'd0, "R4 little-endian value");
    emit_ld(9, 0, 12'd1020, "R5 straddling fail");
    emit_ld(10, 9, 12'd40, "R5 zero after fail");
    emit_ld(0, 7, 12'd0, "R5 load to x0 reads");
    emit_ld(11, 0, 12'd16, "R1 x0 still zero");
    emit_addi(12, 0, 12'hfff);
    emit_addi(13, 12, 12'd1);                    // R2 wrap to zero
    emit_ld(14, 13, 12'd3, "R2 wrap sum");
    emit_addi(15, 0, 12'h7ff);
    emit_addi(15, 15, 12'h800);                  // R2 same reg read/write
    emit_ld(16, 15, 12'd5, "R2 in-place add");
    emit_word({17'h0, 3'b001, 5'd3, 7'b0010011}); // R6 wrong funct3
    run_phase("A");

    // phase B: reset clears registers, then random program
    prog_clear();
    emit_ld(1, 7, 12'd0, "R9 regs cleared");
    for (int i = 0; i < 300; i++) begin
      int r, rd, rs;
      r = $urandom % 10; rd = $urandom % 32; rs = $urandom % 32;
      if (r < 4)      emit_addi(rd, 0, 12'($urandom % 1000));
      else if (r < 7) emit_addi(rd, rs, 12'($urandom));
      else            emit_ld(rd, rs, 12'($urandom % 32), "R3 random load addr");
    end
    begin
      logic [31:0] w;
      w = $urandom;
      while (is_legal(w)) w = $urandom;
      emit_word(w);                              // R6 random illegal
    end
    run_phase("B");

    // phase C: illegal first word, load opcode with wrong width
    prog_clear();
    emit_word({17'h0, 3'b010, 5'd4, 7'b0000011});
    run_phase("C");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule